// File: doc/BRIEF.md
# UART Receiver with Per-Character Status Queue

This block turns an asynchronous serial line into received characters. The line is sampled on a clock-enable that runs at sixteen times the bit rate. Each completed character goes into an eight-entry queue, and each entry carries its own break, framing-error and parity-error flags. The CPU side sees the oldest entry at all times and removes it with a one-cycle read strobe. A sticky overrun flag, a queue-full flag and a data-ready flag summarise the queue. A one-cycle break-change pulse marks both the start and the end of a line break.

Behind the queue sits a one-character holding stage. When the queue is full, a completed character waits there and moves in on the next read. A break is stored once, in a single entry. The receiver then accepts nothing until the line has been high for half a bit time.

Top module: `uart_rx_stat`

## Requirements
- R1: The line is sampled once per `tick16`. A low sample in idle is a start candidate. The start is accepted only if the line is still low on the 8th following tick. A start that fails this check stores nothing and returns the receiver to idle.
- R2: `cfg_len` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. Data bits arrive least significant first, at one sample per 16 ticks. Bits above the programmed length read as zero in `head_data`.
- R3: `cfg_par` selects the parity mode, and a parity bit follows the last data bit in every mode except code 0. The codes are:
  - 0: no parity; `head_pe` is 0.
  - 1: parity check; `cfg_odd`=1 selects odd parity and 0 selects even, and `head_pe` is 1 when the parity is wrong.
  - 2: forced parity; `head_pe` is 1 when the received parity bit differs from `cfg_odd`.
  - 3: address/data mode; `head_pe` holds the received parity bit unchanged.
- R4: The stop bit is sampled at its middle. A low sample there sets `head_fe` for that character.
- R5: A break is a character whose data bits, parity bit (if any) and stop bit are all 0. It is stored as one entry with `head_brk`=1, `head_fe`=1 and data 0. No further entry is stored until the line has been high for 8 consecutive ticks.
- R6: `brk_chg` is a one-cycle pulse. It fires when a break is stored and again when the break ends as defined in R5.
- R7: If the line falls in the middle of a character and stays low through the next character, two entries are stored. The interrupted character is stored with `head_fe`=1 and `head_brk`=0, and the next entry is a break.
- R8: With the queue full, a completed character waits in the holding stage. If another character completes while one is waiting, the waiting character is discarded, the new one takes its place, and `ovr` is set.
- R9: `ovr` stays at 1 until `clr_err` is pulsed.
- R10: `full` is 1 when all eight entries are occupied. A read while a character waits keeps `full` at 1, because the waiting character moves in. A read with nothing waiting clears `full`.
- R11: `rdy` is 1 while at least one entry is stored. It goes to 0 when a read removes the last entry.
- R12: After a synchronous reset, `rdy`, `full`, `ovr` and `brk_chg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sample enable at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len | input | 2 | Data length code: 0..3 for 5..8 bits |
| cfg_par | input | 2 | Parity mode: 0 none, 1 check, 2 forced, 3 address/data |
| cfg_odd | input | 1 | Odd parity select, or the forced parity value |
| rd | input | 1 | Read strobe that removes the head entry |
| clr_err | input | 1 | Clears the overrun flag |
| head_data | output | 8 | Data of the oldest entry |
| head_brk | output | 1 | Break flag of the oldest entry |
| head_fe | output | 1 | Framing-error flag of the oldest entry |
| head_pe | output | 1 | Parity flag of the oldest entry |
| rdy | output | 1 | At least one entry is stored |
| full | output | 1 | All entries are occupied |
| ovr | output | 1 | Sticky overrun flag |
| brk_chg | output | 1 | Pulse at the start and at the end of a break |

## Verification
The checker watches these properties on every cycle:
- the overrun flag stays set until `clr_err` is pulsed;
- `full` survives a read while a character waits in the holding stage;
- `full` never appears without `rdy`;
- the queue occupancy stays within its depth;
- `brk_chg` is never high for two cycles in a row;
- all flags are clear after reset.

The bench scenarios cover what needs a whole serial frame to show:
- the data bits and parity results for each length and parity mode;
- framing errors;
- rejection of a false start;
- a break occupying exactly one entry, with the break end gated by the half-bit high time;
- a break that begins in the middle of a character;
- which character is lost on overrun.

// File: rtl/urx_pkg.sv
package urx_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_CHECK = 2'd1,
        PAR_FORCE = 2'd2,
        PAR_ADDR  = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic              brk;
        logic              fe;
        logic              pe;
        logic [DATA_W-1:0] data;
    } rx_char_t;

    function automatic logic [3:0] len_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic par_flag(input par_mode_e m, input logic odd,
                                      input logic [DATA_W-1:0] d, input logic p);
        case (m)
            PAR_CHECK: return (^d) ^ p ^ odd;
            PAR_FORCE: return p ^ odd;
            PAR_ADDR:  return p;
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/urx_sampler.sv
module urx_sampler
    import urx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rxd,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic     cfg_odd,
    output logic     done,
    output rx_char_t chr,
    output logic     brk_end
);
    localparam int CW   = $clog2(OSR);
    localparam int HALF = OSR / 2;

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [2:0]        bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              pbit;
    logic [3:0]        nbits;
    par_mode_e         pmode;
    logic              at_mid;
    logic              all_low;

    assign nbits   = len_bits(cfg_len);
    assign pmode   = par_mode_e'(cfg_par);
    assign at_mid  = (cnt == CW'(OSR - 1));
    assign all_low = (shreg == '0) && !pbit && !rxd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            pbit    <= 1'b0;
            done    <= 1'b0;
            brk_end <= 1'b0;
            chr     <= '0;
        end else begin
            done    <= 1'b0;
            brk_end <= 1'b0;
            if (tick) begin
                case (state)
                    S_IDLE: begin
                        if (!rxd) begin
                            state <= S_START;
                            cnt   <= '0;
                        end
                    end
                    S_START: begin
                        if (cnt == CW'(HALF - 1)) begin
                            cnt <= '0;
                            if (!rxd) begin
                                state   <= S_DATA;
                                bit_idx <= '0;
                                shreg   <= '0;
                                pbit    <= 1'b0;
                            end else begin
                                state <= S_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (at_mid) begin
                            cnt            <= '0;
                            shreg[bit_idx] <= rxd;
                            if ({1'b0, bit_idx} == nbits - 4'd1)
                                state <= (pmode == PAR_NONE) ? S_STOP : S_PAR;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_PAR: begin
                        if (at_mid) begin
                            cnt   <= '0;
                            pbit  <= rxd;
                            state <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (at_mid) begin
                            cnt      <= '0;
                            done     <= 1'b1;
                            chr.data <= shreg;
                            chr.fe   <= !rxd;
                            chr.brk  <= all_low;
                            chr.pe   <= par_flag(pmode, cfg_odd, shreg, pbit);
                            state    <= all_low ? S_BRK : S_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_BRK: begin
                        if (!rxd) begin
                            cnt <= '0;
                        end else if (cnt == CW'(HALF - 1)) begin
                            cnt     <= '0;
                            brk_end <= 1'b1;
                            state   <= S_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo
    import urx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  rx_char_t                 din,
    input  logic                     pop,
    output rx_char_t                 dout,
    output logic [$clog2(DEPTH):0]   count
);
    localparam int AW = $clog2(DEPTH);

    rx_char_t      mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          do_pop;

    assign do_pop = pop && (count != '0);
    assign dout   = mem[rptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push)   wptr <= nxt(wptr);
            if (do_pop) rptr <= nxt(rptr);
            case ({push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
    import urx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int OSR   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              rxd,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_odd,
    input  logic              rd,
    input  logic              clr_err,
    output logic [DATA_W-1:0] head_data,
    output logic              head_brk,
    output logic              head_fe,
    output logic              head_pe,
    output logic              rdy,
    output logic              full,
    output logic              ovr,
    output logic              brk_chg
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic             s_done;
    logic             s_brk_end;
    rx_char_t         s_chr;
    rx_char_t         f_din;
    rx_char_t         f_dout;
    logic             f_push;
    logic             f_pop;
    logic [CNT_W-1:0] f_count;
    logic             f_space;
    logic             hold_v;
    rx_char_t         hold_c;
    logic             hold_move;

    urx_sampler #(.OSR(OSR)) u_smp (
        .clk(clk), .rst(rst), .tick(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_odd(cfg_odd),
        .done(s_done), .chr(s_chr), .brk_end(s_brk_end)
    );

    urx_fifo #(.DEPTH(DEPTH)) u_q (
        .clk(clk), .rst(rst), .push(f_push), .din(f_din),
        .pop(f_pop), .dout(f_dout), .count(f_count)
    );

    assign f_pop     = rd && (f_count != '0);
    assign full      = (f_count == CNT_W'(DEPTH));
    assign f_space   = !full || f_pop;
    assign hold_move = hold_v && f_space;

    always_comb begin
        f_push = 1'b0;
        f_din  = hold_c;
        if (hold_move) begin
            f_push = 1'b1;
        end else if (!hold_v && s_done && f_space) begin
            f_push = 1'b1;
            f_din  = s_chr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v <= 1'b0;
            hold_c <= '0;
            ovr    <= 1'b0;
        end else begin
            if (clr_err) ovr <= 1'b0;
            if (s_done && (hold_v || !f_space)) begin
                hold_c <= s_chr;
                hold_v <= 1'b1;
                if (hold_v && !f_space) ovr <= 1'b1;
            end else if (hold_move) begin
                hold_v <= 1'b0;
            end
        end
    end

    assign head_data = f_dout.data;
    assign head_brk  = f_dout.brk;
    assign head_fe   = f_dout.fe;
    assign head_pe   = f_dout.pe;
    assign rdy       = (f_count != '0);
    assign brk_chg   = (s_done && s_chr.brk) || s_brk_end;
endmodule

// File: rtl/urx_checker.sv
module urx_checker #(
    parameter int DEPTH = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   rd,
    input logic                   clr_err,
    input logic                   rdy,
    input logic                   full,
    input logic                   ovr,
    input logic                   brk_chg,
    input logic                   hold_v,
    input logic [$clog2(DEPTH):0] count
);
    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        ovr && !clr_err |=> ovr);

    a_r10_full_kept: assert property (@(posedge clk) disable iff (rst)
        full && rd && hold_v |=> full);

    a_r11_full_has_rdy: assert property (@(posedge clk) disable iff (rst)
        full |-> rdy);

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= ($clog2(DEPTH) + 1)'(DEPTH));

    a_r6_brk_one_cycle: assert property (@(posedge clk) disable iff (rst)
        brk_chg |=> !brk_chg);

    a_r12_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rdy && !full && !ovr && !brk_chg);
endmodule

bind uart_rx_stat urx_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .rd(rd), .clr_err(clr_err), .rdy(rdy),
    .full(full), .ovr(ovr), .brk_chg(brk_chg), .hold_v(hold_v),
    .count(f_count)
);

// File: tb/sim_uart_rx_stat.sv
module sim_uart_rx_stat;
    localparam int BIT_CYC = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_odd = 1'b0;
    logic       rd = 1'b0;
    logic       clr_err = 1'b0;
    logic [7:0] head_data;
    logic       head_brk, head_fe, head_pe, rdy, full, ovr, brk_chg;

    int n_chk = 0;
    int n_fail = 0;
    int brk_cnt = 0;

    always #5 clk = ~clk;

    uart_rx_stat u0 (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_odd(cfg_odd),
        .rd(rd), .clr_err(clr_err), .head_data(head_data),
        .head_brk(head_brk), .head_fe(head_fe), .head_pe(head_pe),
        .rdy(rdy), .full(full), .ovr(ovr), .brk_chg(brk_chg)
    );

    initial forever begin
        @(negedge clk);
        tick16 = ~tick16;
    end

    initial forever begin
        @(negedge clk);
        if (brk_chg) brk_cnt++;
    end

    typedef struct packed {
        logic [1:0] len;
        logic [1:0] par;
        logic       odd;
        logic [7:0] data;
        logic       pbit;
        logic       stop;
        logic [7:0] exp_d;
        logic       exp_fe;
        logic       exp_pe;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{2'd3, 2'd0, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0},
        '{2'd0, 2'd0, 1'b0, 8'hF3, 1'b0, 1'b1, 8'h13, 1'b0, 1'b0},
        '{2'd2, 2'd1, 1'b0, 8'h55, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0},
        '{2'd2, 2'd1, 1'b0, 8'h55, 1'b1, 1'b1, 8'h55, 1'b0, 1'b1},
        '{2'd3, 2'd1, 1'b1, 8'h0F, 1'b1, 1'b1, 8'h0F, 1'b0, 1'b0},
        '{2'd1, 2'd2, 1'b1, 8'h2A, 1'b0, 1'b1, 8'h2A, 1'b0, 1'b1},
        '{2'd1, 2'd2, 1'b0, 8'h15, 1'b0, 1'b1, 8'h15, 1'b0, 1'b0},
        '{2'd3, 2'd3, 1'b0, 8'h81, 1'b1, 1'b1, 8'h81, 1'b0, 1'b1},
        '{2'd3, 2'd3, 1'b0, 8'h12, 1'b0, 1'b1, 8'h12, 1'b0, 1'b0},
        '{2'd3, 2'd0, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input logic pb, input logic stp);
        drive_bit(1'b0);
        for (int i = 0; i < 5 + int'(cfg_len); i++) drive_bit(d[i]);
        if (cfg_par != 2'd0) drive_bit(pb);
        drive_bit(stp);
        drive_bit(1'b1);
    endtask

    task automatic read_one();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        check("R12 rdy", rdy, 0);
        check("R12 full", full, 0);
        check("R12 ovr", ovr, 0);
        check("R12 brk_chg", brk_chg, 0);

        // R1 false starts: 3 ticks and 6 ticks low
        rxd = 1'b0; repeat (6) @(negedge clk);
        rxd = 1'b1; repeat (64) @(negedge clk);
        rxd = 1'b0; repeat (12) @(negedge clk);
        rxd = 1'b1; repeat (64) @(negedge clk);
        check("R1 false start ignored", rdy, 0);

        // R2 R3 R4 vector table
        for (int v = 0; v < NV; v++) begin
            cfg_len = VT[v].len;
            cfg_par = VT[v].par;
            cfg_odd = VT[v].odd;
            send_char(VT[v].data, VT[v].pbit, VT[v].stop);
            check("R11 rdy set", rdy, 1);
            check("R2 data", head_data, VT[v].exp_d);
            check("R4 framing", head_fe, VT[v].exp_fe);
            check("R3 parity flag", head_pe, VT[v].exp_pe);
            check("R5 no break", head_brk, 0);
            read_one();
            check("R11 rdy clear", rdy, 0);
        end

        // R8 R9 R10 overrun and holding stage, 8N
        cfg_len = 2'd3; cfg_par = 2'd0;
        for (int i = 0; i < 8; i++) send_char(8'h10 + 8'(i), 1'b0, 1'b1);
        check("R10 full at 8", full, 1);
        send_char(8'h20, 1'b0, 1'b1);
        check("R8 waiting no ovr", ovr, 0);
        check("R10 still full", full, 1);
        check("R8 head unchanged", head_data, 8'h10);
        send_char(8'h30, 1'b0, 1'b1);
        check("R8 overrun set", ovr, 1);
        read_one();
        check("R10 full kept by waiting char", full, 1);
        check("R8 head after read", head_data, 8'h11);
        read_one();
        check("R10 full cleared", full, 0);
        for (int i = 2; i < 8; i++) begin
            check("R8 order", head_data, 8'h10 + 8'(i));
            read_one();
        end
        check("R8 newest kept, older waiting lost", head_data, 8'h30);
        read_one();
        check("R11 empty", rdy, 0);
        check("R9 ovr sticky", ovr, 1);
        clr_err = 1'b1; @(negedge clk); clr_err = 1'b0; @(negedge clk);
        check("R9 ovr cleared", ovr, 0);

        // R5 R6 break
        brk_cnt = 0;
        rxd = 1'b0;
        repeat (14 * BIT_CYC) @(negedge clk);
        check("R6 break start pulse", brk_cnt, 1);
        check("R5 break entry", rdy, 1);
        check("R5 break flag", head_brk, 1);
        check("R5 break fe", head_fe, 1);
        check("R5 break data", head_data, 0);
        read_one();
        rxd = 1'b1; repeat (6) @(negedge clk);
        rxd = 1'b0; repeat (4 * BIT_CYC) @(negedge clk);
        check("R5 single entry", rdy, 0);
        check("R6 short high not end", brk_cnt, 1);
        rxd = 1'b1; repeat (2 * BIT_CYC) @(negedge clk);
        check("R6 break end pulse", brk_cnt, 2);
        send_char(8'h5A, 1'b0, 1'b1);
        check("R5 normal after break", head_data, 8'h5A);
        check("R5 normal no brk", head_brk, 0);
        read_one();

        // R7 break starting mid character
        brk_cnt = 0;
        drive_bit(1'b0);
        drive_bit(1'b1); drive_bit(1'b1); drive_bit(1'b1);
        rxd = 1'b0;
        repeat (16 * BIT_CYC) @(negedge clk);
        check("R7 interrupted data", head_data, 8'h07);
        check("R7 interrupted fe", head_fe, 1);
        check("R7 interrupted not brk", head_brk, 0);
        read_one();
        check("R7 break follows", head_brk, 1);
        read_one();
        check("R7 two entries only", rdy, 0);
        rxd = 1'b1; repeat (2 * BIT_CYC) @(negedge clk);
        check("R7 break pulses", brk_cnt, 2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule